// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a small synchronous static memory built for bus alternation without idle cycles. The operation code, address, byte-lane selects and chip enables are sampled on one rising clock edge. The data transfer for that operation takes place in the cycle that follows. During a read's data cycle, the word comes straight out of the array onto the output with no output register. A write's data is sampled on the next enabled edge, which closes its data cycle. Because every data phase trails its command by exactly one cycle, a read may follow a write, and a write may follow a read, on consecutive clocks.

The bidirectional data bus is presented as three ports: separate input, output and output-enable. An asynchronous active-low output enable gates the drive. An active-low clock enable freezes the whole block. A sleep input also turns the drive off and drops work. Burst address generation lives outside the block: a neighbouring sequencer supplies each effective address. The load/advance control selects between two behaviours. It either starts a new operation, or it continues the current operation type at the supplied address. Each word has four 9-bit byte lanes.

Top module: `zt_sram`

## Requirements
- R1: A command sampled on an enabled rising edge has its data cycle between that edge and the next one; a read command makes the addressed word visible on `dOut` during that cycle.
- R2: `dOut` is zero in any cycle that is not the data cycle of a read. `dOe` is high only in a read data cycle while `outEnN` is low and `sleep` is low.
- R3: `outEnN` acts without the clock. Taking it high turns `dOe` off at once, and `dOut` still carries the read word.
- R4: While `clkEnN` is high, every sampled input is ignored and all state holds. A pending read keeps driving the same word. A pending write is not committed until an edge with `clkEnN` low.
- R5: The device is selected only when `selN0`=0, `sel1`=1 and `selN2`=0. A load (`loadN`=0) with any enable inactive starts no operation. A write already pending still commits its data on that edge.
- R6: `dOe` is low in the cycle after a deselecting load, and in the cycle after a write load (`wrN`=0).
- R7: Writes and reads alternate on consecutive edges with no idle cycle. A read loaded on the edge that commits a write to the same address returns the newly written word.
- R8: Byte lane i is bits [9i+8:9i] of the data word. It is written only if `laneWrN[i]` was 0 when the write command was sampled.
- R9: An advance (`loadN`=1) repeats the pending operation type at the new `addrIn` with the new lane selects, and ignores `wrN` and the chip enables. An advance with no operation pending stays idle.
- R10: While `sleep` is high, `dOe` is low and no command is accepted. A write pending at a sleeping edge is dropped. Array contents are kept.
- R11: An active-low asynchronous `rstN` clears any pending operation, forcing `dOe` and `dOut` to zero at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEnN | input | 1 | Clock enable, active low; high freezes the block |
| sleep | input | 1 | Power-down request, active high |
| outEnN | input | 1 | Asynchronous output enable, active low |
| loadN | input | 1 | 0 loads a new command, 1 advances the current one |
| wrN | input | 1 | 0 write, 1 read (sampled on load) |
| selN0 | input | 1 | Chip enable, active low |
| sel1 | input | 1 | Chip enable, active high |
| selN2 | input | 1 | Chip enable, active low |
| addrIn | input | 4 | Effective word address from the burst sequencer |
| laneWrN | input | 4 | Per-lane write selects, active low |
| dIn | input | 36 | Write data, sampled on the edge ending the data cycle |
| dOut | output | 36 | Flow-through read data |
| dOe | output | 1 | Drive enable for the external data bus |

## Verification
The hardest situations to reach are clock-enable stalls that land in the middle of a data cycle. The same applies when a read and the commit of a write share an edge. The stimulus therefore stalls the bench while a read is driving, then checks that the word holds. It also stalls between a write command and its data, feeding junk data on the frozen edge before the real data arrives with a read of the same address. A further run leaves a write pending across a deselect, an advance chain and a sleep edge, then reads each location back to tell a committed write from a dropped one.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic rdEn;
    logic wrEn;
  } strobe_t;
endpackage

// File: rtl/zt_sram_ctrl.sv
module zt_sram_ctrl
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              sleep,
  input  logic              loadN,
  input  logic              wrN,
  input  logic              selN0,
  input  logic              sel1,
  input  logic              selN2,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [LANES-1:0]  laneWrN,
  output strobe_t           stb,
  output logic [ADDR_W-1:0] pendAddr,
  output logic [LANES-1:0]  laneEn
);
  op_e              pendOp;
  op_e              nextOp;
  logic [LANES-1:0] pendLaneN;
  logic             chipSel;

  assign chipSel = !selN0 && sel1 && !selN2;

  always_comb begin
    if (!loadN) begin
      if (!chipSel)  nextOp = OP_IDLE;
      else if (wrN)  nextOp = OP_READ;
      else           nextOp = OP_WRITE;
    end else begin
      nextOp = pendOp;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendOp    <= OP_IDLE;
      pendAddr  <= '0;
      pendLaneN <= '1;
    end else if (!clkEnN) begin
      if (sleep) begin
        pendOp <= OP_IDLE;
      end else begin
        pendOp    <= nextOp;
        pendAddr  <= addrIn;
        pendLaneN <= laneWrN;
      end
    end
  end

  always_comb begin
    stb.rdEn = (pendOp == OP_READ) && !sleep;
    stb.wrEn = (pendOp == OP_WRITE) && !clkEnN && !sleep;
  end

  assign laneEn = ~pendLaneN;
endmodule

// File: rtl/zt_sram_dpath.sv
module zt_sram_dpath
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  strobe_t                 stb,
  input  logic [ADDR_W-1:0]       pendAddr,
  input  logic [LANES-1:0]        laneEn,
  input  logic [LANES*LANE_W-1:0] dIn,
  output logic [LANES*LANE_W-1:0] dOut
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] arrWord;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (stb.wrEn && laneEn[g])
        laneMem[pendAddr] <= dIn[g*LANE_W +: LANE_W];
    end

    assign arrWord[g*LANE_W +: LANE_W] = laneMem[pendAddr];
  end

  // flow-through: no output register
  assign dOut = stb.rdEn ? arrWord : '0;
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              sleep,
  input  logic              outEnN,
  input  logic              loadN,
  input  logic              wrN,
  input  logic              selN0,
  input  logic              sel1,
  input  logic              selN2,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [LANES-1:0]  laneWrN,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOe
);
  strobe_t           stb;
  logic [ADDR_W-1:0] pendAddr;
  logic [LANES-1:0]  laneEn;

  zt_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .sleep(sleep),
    .loadN(loadN), .wrN(wrN), .selN0(selN0), .sel1(sel1), .selN2(selN2),
    .addrIn(addrIn), .laneWrN(laneWrN),
    .stb(stb), .pendAddr(pendAddr), .laneEn(laneEn)
  );

  zt_sram_dpath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dpath (
    .clk(clk), .stb(stb), .pendAddr(pendAddr), .laneEn(laneEn),
    .dIn(dIn), .dOut(dOut)
  );

  assign dOe = stb.rdEn && !outEnN && !sleep;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEnN,
  input logic              sleep,
  input logic              outEnN,
  input logic              loadN,
  input logic              wrN,
  input logic              selN0,
  input logic              sel1,
  input logic              selN2,
  input logic [DATA_W-1:0] dOut,
  input logic              dOe
);
  logic selOk;
  assign selOk = !selN0 && sel1 && !selN2;

  // R3
  out_en_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !dOe);

  // R10
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !dOe);

  // R6
  deselect_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !sleep && !loadN && !selOk) |=> !dOe);

  // R6
  write_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !sleep && !loadN && selOk && !wrN) |=> !dOe);

  // R1
  read_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !sleep && !loadN && selOk && wrN) |=> (dOe || outEnN || sleep));

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkEnN && !sleep) |=> (sleep || $stable(dOut)));

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !sleep && !loadN && !selOk) |=> (dOut == '0));
endmodule

bind zt_sram zt_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .sleep(sleep), .outEnN(outEnN),
  .loadN(loadN), .wrN(wrN), .selN0(selN0), .sel1(sel1), .selN2(selN2),
  .dOut(dOut), .dOe(dOe)
);

// File: tb/zt_sram_bench.sv
module zt_sram_bench;
  localparam int AW = 4;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;
  localparam logic [2:0] SEL = 3'b010;  // {selN0, sel1, selN2}
  localparam logic [3:0] ALL = 4'b0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clkEnN = 1'b0, sleep = 1'b0, outEnN = 1'b0, loadN = 1'b1, wrN = 1'b1;
  logic selN0 = 1'b1, sel1 = 1'b0, selN2 = 1'b1;
  logic [AW-1:0] addrIn = '0;
  logic [NL-1:0] laneWrN = '1;
  logic [DW-1:0] dIn = '0;
  logic [DW-1:0] dOut;
  logic          dOe;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  zt_sram u_zt_sram (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .sleep(sleep), .outEnN(outEnN),
    .loadN(loadN), .wrN(wrN), .selN0(selN0), .sel1(sel1), .selN2(selN2),
    .addrIn(addrIn), .laneWrN(laneWrN), .dIn(dIn), .dOut(dOut), .dOe(dOe)
  );

  typedef struct {
    logic          oe;
    logic [DW-1:0] d;
    string         req;
  } item_t;

  item_t expQ[$];

  // bench model of the storage and the pending command
  logic [DW-1:0] mMem [16];
  logic [1:0]    mOp = 2'd0;   // 0 idle, 1 read, 2 write
  logic [AW-1:0] mA = '0;
  logic [NL-1:0] mLn = '1;

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic cen, input logic slp, input logic oeN,
                      input logic ld, input logic wr, input logic [2:0] en,
                      input logic [AW-1:0] a, input logic [NL-1:0] ln,
                      input logic [DW-1:0] d, input string req);
    item_t it;
    logic  rd;
    @(negedge clk);
    clkEnN = cen; sleep = slp; outEnN = oeN; loadN = ld; wrN = wr;
    {selN0, sel1, selN2} = en; addrIn = a; laneWrN = ln; dIn = d;
    if (!cen && !slp && mOp == 2'd2)
      for (int i = 0; i < NL; i++)
        if (!mLn[i]) mMem[mA][i*LW +: LW] = d[i*LW +: LW];
    if (!cen) begin
      if (slp) mOp = 2'd0;
      else begin
        if (!ld) mOp = (en == SEL) ? (wr ? 2'd1 : 2'd2) : 2'd0;
        mA = a; mLn = ln;
      end
    end
    rd = (mOp == 2'd1) && !slp;
    it.oe = rd && !oeN;
    it.d = rd ? mMem[mA] : '0;
    it.req = req;
    expQ.push_back(it);
  endtask

  // monitor: sample 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        item_t e;
        e = expQ.pop_front();
        check({{(DW-1){1'b0}}, dOe}, {{(DW-1){1'b0}}, e.oe}, {e.req, " dOe"});
        check(dOut, e.d, {e.req, " dOut"});
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        bad++;
        $display("FAIL watchdog actual=%0d expected<5000 cycles", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  localparam logic [DW-1:0] DA = 36'h1_2345_6789;
  localparam logic [DW-1:0] DB = 36'hA_BCDE_F012;
  localparam logic [DW-1:0] DC = 36'h5_5AA5_A55A;
  localparam logic [DW-1:0] DD = 36'h3_0F0F_0F0F;
  localparam logic [DW-1:0] DE = 36'hC_1357_9BDF;
  localparam logic [DW-1:0] DF = 36'h7_7777_0001;
  localparam logic [DW-1:0] DG = 36'h9_8765_4321;

  initial begin
    for (int i = 0; i < 16; i++) mMem[i] = '0;
    repeat (3) @(posedge clk);
    #2;
    // R11 reset state
    check({{(DW-1){1'b0}}, dOe}, '0, "R11 reset dOe");
    check(dOut, '0, "R11 reset dOut");
    @(negedge clk);
    rstN = 1'b1;

    // R1 / R7 alternation, read right after write to same address
    step(0,0,0,0,0,SEL,4'd3,ALL,'0,"R1");
    step(0,0,0,0,1,SEL,4'd3,ALL,DA,"R7");
    step(0,0,0,0,0,SEL,4'd5,ALL,'0,"R7");
    step(0,0,0,0,1,SEL,4'd5,ALL,DB,"R7");
    // R8 partial lanes: lanes 0 and 2 written
    step(0,0,0,0,0,SEL,4'd3,4'b1010,'0,"R8");
    step(0,0,0,0,1,SEL,4'd3,ALL,DC,"R8");
    // R4 stall while read drives, and between write command and data
    step(0,0,0,0,1,SEL,4'd5,ALL,'0,"R4");
    step(1,0,0,0,0,SEL,4'd3,ALL,DC,"R4");
    step(0,0,0,0,0,SEL,4'd7,ALL,'0,"R2");
    step(1,0,0,0,1,SEL,4'd3,ALL,36'hF_FFFF_FFFF,"R4");
    step(0,0,0,0,1,SEL,4'd7,ALL,DD,"R4");
    // R5 each enable inactive
    step(0,0,0,0,1,3'b110,4'd3,ALL,'0,"R5");
    step(0,0,0,0,1,3'b000,4'd3,ALL,'0,"R5");
    step(0,0,0,0,1,3'b011,4'd3,ALL,'0,"R5");
    // R6 write load floats bus; R5 pending write completes after deselect
    step(0,0,0,0,0,SEL,4'd9,ALL,'0,"R6");
    step(0,0,0,0,1,3'b110,4'd9,ALL,DE,"R5");
    step(0,0,0,0,1,SEL,4'd9,ALL,'0,"R5");
    step(0,0,0,0,1,SEL,4'd3,ALL,'0,"R7");
    // R9 advance
    step(0,0,0,1,0,3'b110,4'd5,ALL,'0,"R9");
    step(0,0,0,0,0,SEL,4'd10,ALL,'0,"R9");
    step(0,0,0,1,1,3'b000,4'd11,ALL,DF,"R9");
    step(0,0,0,0,1,SEL,4'd10,ALL,DG,"R9");
    step(0,0,0,1,0,3'b000,4'd11,ALL,'0,"R9");
    step(0,0,0,0,1,3'b110,4'd0,ALL,'0,"R6");
    step(0,0,0,1,1,SEL,4'd5,ALL,'0,"R9");
    // R3 output enable
    step(0,0,1,0,1,SEL,4'd3,ALL,'0,"R3");
    step(0,0,0,0,1,SEL,4'd9,ALL,'0,"R3");
    @(posedge clk);
    #3 outEnN = 1'b1;
    #1 check({{(DW-1){1'b0}}, dOe}, '0, "R3 async off");
    check(dOut, DE, "R3 data kept");
    outEnN = 1'b0;
    #0.5 check({{(DW-1){1'b0}}, dOe}, 36'd1, "R3 async on");
    // R10 sleep
    step(0,0,0,0,0,SEL,4'd3,ALL,'0,"R10");
    step(0,1,0,0,1,SEL,4'd3,ALL,36'h0_0000_0BAD,"R10");
    step(0,1,0,0,1,SEL,4'd5,ALL,'0,"R10");
    step(0,0,0,0,1,SEL,4'd3,ALL,'0,"R10");
    step(0,0,0,0,1,SEL,4'd7,ALL,'0,"R10");
    // R11 asynchronous reset during a read
    @(posedge clk);
    #3 rstN = 1'b0;
    #1 check({{(DW-1){1'b0}}, dOe}, '0, "R11 async dOe");
    check(dOut, '0, "R11 async dOut");
    repeat (3) @(posedge clk);
    #3;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule